// File: doc/BRIEF.md
# Bitfield Extract and Insert Unit

This unit performs the two field operations a processor datapath needs for packed data on a register word. In extract mode it picks a contiguous field out of the source operand and returns it aligned to bit 0, with zeros above it. In insert mode it takes the low-order bits of the source operand and writes them into a copy of a destination operand at a chosen bit offset. The destination keeps every bit outside the field.

The field is described by a start offset and a width. The width is encoded as width minus one, so every width from one bit up to the full word can be coded. When offset plus width reaches past the top bit of the word, the unit follows a fixed policy. It raises an invalid flag, and only the part of the field that lies inside the word takes part in the operation.

The result and the flag leave through a register stage by default. A parameter removes that stage for a purely combinational build. The decoder that feeds the unit and the register file that receives its output are outside this block.

Top module: `bitfield_unit`

## Requirements
- R1: In extract mode (op_i = 0), result bit k equals rs_i bit (pos_i + k) for every k from 0 to the field width minus one, provided pos_i + k lies inside the word.
- R2: In extract mode, every result bit at or above the field width is 0.
- R3: In insert mode (op_i = 1), result bit (pos_i + k) equals rs_i bit k for every k in the field for which pos_i + k lies inside the word.
- R4: In insert mode, every result bit outside the field equals the corresponding bit of rt_i.
- R5: The field width is size_m1_i + 1, giving 1 to 32 bits. An extract with pos_i = 0 and size_m1_i = 31 returns rs_i unchanged.
- R6: invalid_o is 1 exactly when pos_i + size_m1_i + 1 > 32, in both modes.
- R7: When the field overflows, extract returns only rs_i bits pos_i..31, with zeros above them. Insert writes only result bits pos_i..31, and the rs_i bits that would land above bit 31 are dropped.
- R8: With the default register stage, result_o and invalid_o show the operation one clock after the inputs are presented. While rst_n is low both outputs are 0.
- R9: In extract mode, rt_i has no effect on result_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register stage |
| rst_n | input | 1 | Active-low reset; clears the outputs |
| op_i | input | 1 | Operation: 0 = extract, 1 = insert |
| rs_i | input | 32 | Source word; supplies the field for both modes |
| rt_i | input | 32 | Destination word; read only by insert |
| pos_i | input | 5 | Bit offset of the field's low end |
| size_m1_i | input | 5 | Field width minus one |
| result_o | output | 32 | Extracted field or merged word |
| invalid_o | output | 1 | Field crosses the top of the word |

## Verification
Extract runs on a dense word, on alternating bits and on a single set bit. The dense word and the alternating bits separate a correct shift from an off-by-one offset. The single set bit shows whether the width mask is exact at its top edge. Insert merges an all-ones source into an all-zeros destination and the reverse, which shows both field edges and the pass-through of the bits around them. Fields that end exactly at bit 31 are compared with fields one bit longer, which pins down the invalid flag and the clipping. An extract repeated with a different destination word shows that the destination has no effect in that mode.

// File: rtl/bitfield_pkg.sv
`timescale 1ns/1ps
package bitfield_pkg;
   typedef enum logic {
      BF_OP_EXTRACT = 1'b0,
      BF_OP_INSERT  = 1'b1
   } bf_op_e;

   // Width of the sum of two field descriptors (offset + width-1)
   function automatic int bf_sum_width(input int pos_w);
      return pos_w + 1;
   endfunction
endpackage

// File: rtl/bitfield_mask_gen.sv
`timescale 1ns/1ps
// Builds the two masks used by the datapath and the overflow flag.
//   low_mask_o   : bits 0..size set (field aligned to bit 0)
//   field_mask_o : bits pos..pos+size set, clipped at the word top
module bitfield_mask_gen #(
   parameter int W     = 32,
   parameter int POS_W = $clog2(W)
) (
   input  logic [POS_W-1:0] pos_i,
   input  logic [POS_W-1:0] size_m1_i,
   output logic [W-1:0]     low_mask_o,
   output logic [W-1:0]     field_mask_o,
   output logic             ovf_o
);
   localparam int SUM_W = bitfield_pkg::bf_sum_width(POS_W);
   localparam logic [SUM_W-1:0] WORD_BITS = SUM_W'(W);

   logic [SUM_W-1:0] pos_ext;
   logic [SUM_W-1:0] size_ext;
   logic [SUM_W-1:0] top_idx;

   assign pos_ext  = {1'b0, pos_i};
   assign size_ext = {1'b0, size_m1_i};
   assign top_idx  = pos_ext + size_ext;

   // Overflow: last bit index of the field at or beyond W
   generate
      if ((1 << POS_W) == W) begin : g_ovf_pow2
         assign ovf_o = top_idx[SUM_W-1];
      end else begin : g_ovf_cmp
         assign ovf_o = (top_idx >= WORD_BITS);
      end
   endgenerate

   for (genvar i = 0; i < W; i++) begin : g_bit
      localparam logic [SUM_W-1:0] IDX = SUM_W'(i);
      logic above_lo;
      logic below_hi;
      assign above_lo           = (IDX >= pos_ext);
      assign below_hi           = (IDX <= top_idx);
      assign field_mask_o[i]    = above_lo & below_hi;
      assign low_mask_o[i]      = (IDX <= size_ext);
   end
endmodule

// File: rtl/bitfield_extract.sv
`timescale 1ns/1ps
// Right-justified field extraction; zeros fill above the field.
module bitfield_extract #(
   parameter int W     = 32,
   parameter int POS_W = $clog2(W)
) (
   input  logic [W-1:0]     rs_i,
   input  logic [POS_W-1:0] pos_i,
   input  logic [W-1:0]     low_mask_i,
   output logic [W-1:0]     field_o
);
   logic [W-1:0] aligned;
   // Logical shift brings zeros in from the top, so bits past the
   // word end are naturally zero (clipping policy).
   assign aligned = rs_i >> pos_i;
   assign field_o = aligned & low_mask_i;
endmodule

// File: rtl/bitfield_insert.sv
`timescale 1ns/1ps
// Merges low-order source bits into the destination at an offset.
module bitfield_insert #(
   parameter int W     = 32,
   parameter int POS_W = $clog2(W)
) (
   input  logic [W-1:0]     rs_i,
   input  logic [W-1:0]     rt_i,
   input  logic [POS_W-1:0] pos_i,
   input  logic [W-1:0]     field_mask_i,
   output logic [W-1:0]     merged_o
);
   logic [W-1:0] placed;
   // Left shift drops source bits that would land past the top.
   assign placed   = rs_i << pos_i;
   assign merged_o = (rt_i & ~field_mask_i) | (placed & field_mask_i);
endmodule

// File: rtl/bitfield_unit.sv
`timescale 1ns/1ps
module bitfield_unit #(
   parameter int W       = 32,
   parameter int POS_W   = $clog2(W),
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_i,
   input  logic [W-1:0]     rs_i,
   input  logic [W-1:0]     rt_i,
   input  logic [POS_W-1:0] pos_i,
   input  logic [POS_W-1:0] size_m1_i,
   output logic [W-1:0]     result_o,
   output logic             invalid_o
);
   import bitfield_pkg::*;

   // Elaboration-time parameter checks
   if (W < 2) begin : g_bad_w
      $error("bitfield_unit: W must be at least 2");
   end
   if ((1 << POS_W) < W) begin : g_bad_pos_w
      $error("bitfield_unit: POS_W too narrow to address W bits");
   end

   logic [W-1:0] low_mask;
   logic [W-1:0] field_mask;
   logic         ovf;
   logic [W-1:0] ext_res;
   logic [W-1:0] ins_res;
   logic [W-1:0] res_d;
   bf_op_e       op_sel;

   assign op_sel = bf_op_e'(op_i);

   bitfield_mask_gen #(.W(W), .POS_W(POS_W)) u_mask (
      .pos_i        (pos_i),
      .size_m1_i    (size_m1_i),
      .low_mask_o   (low_mask),
      .field_mask_o (field_mask),
      .ovf_o        (ovf)
   );

   bitfield_extract #(.W(W), .POS_W(POS_W)) u_ext (
      .rs_i       (rs_i),
      .pos_i      (pos_i),
      .low_mask_i (low_mask),
      .field_o    (ext_res)
   );

   bitfield_insert #(.W(W), .POS_W(POS_W)) u_ins (
      .rs_i         (rs_i),
      .rt_i         (rt_i),
      .pos_i        (pos_i),
      .field_mask_i (field_mask),
      .merged_o     (ins_res)
   );

   always_comb begin
      unique case (op_sel)
         BF_OP_INSERT:  res_d = ins_res;
         default:       res_d = ext_res;
      endcase
   end

   generate
      if (OUT_REG) begin : g_out_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               result_o  <= '0;
               invalid_o <= 1'b0;
            end else begin
               result_o  <= res_d;
               invalid_o <= ovf;
            end
         end
      end else begin : g_out_comb
         assign result_o  = res_d;
         assign invalid_o = ovf;
      end
   endgenerate
endmodule

// File: rtl/bitfield_unit_chk.sv
`timescale 1ns/1ps
module bitfield_unit_chk #(
   parameter int W       = 32,
   parameter int POS_W   = $clog2(W),
   parameter bit OUT_REG = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             op_i,
   input logic [W-1:0]     rs_i,
   input logic [W-1:0]     rt_i,
   input logic [POS_W-1:0] pos_i,
   input logic [POS_W-1:0] size_m1_i,
   input logic [W-1:0]     result_o,
   input logic             invalid_o
);
   localparam int SUM_W = POS_W + 1;

   if (OUT_REG) begin : g_reg_chk
      AST_EXT_LSB: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && !$past(op_i)) |-> (result_o[0] == $past(rs_i[pos_i]))); // R1

      AST_EXT_ZERO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && !$past(op_i)) |->
            ((result_o >> (32'($past(size_m1_i)) + 32'd1)) == '0)); // R2

      AST_INS_FIELD_LSB: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(op_i)) |-> (result_o[$past(pos_i)] == $past(rs_i[0]))); // R3

      AST_INS_LOW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(op_i)) |->
            (((result_o ^ $past(rt_i)) & ((W'(1) << $past(pos_i)) - W'(1))) == '0)); // R4

      AST_FULL_EXTRACT: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && !$past(op_i) && ($past(pos_i) == '0) && ($past(size_m1_i) == '1))
            |-> (result_o == $past(rs_i))); // R5

      AST_NO_OVERFLOW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> (invalid_o ==
            ((SUM_W'($past(pos_i)) + SUM_W'($past(size_m1_i))) >= SUM_W'(W)))); // R6
   end
endmodule

bind bitfield_unit bitfield_unit_chk #(.W(W), .POS_W(POS_W), .OUT_REG(OUT_REG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_i      (op_i),
   .rs_i      (rs_i),
   .rt_i      (rt_i),
   .pos_i     (pos_i),
   .size_m1_i (size_m1_i),
   .result_o  (result_o),
   .invalid_o (invalid_o)
);

// File: tb/bitfield_unit_tb_top.sv
`timescale 1ns/1ps
module bitfield_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_i = 1'b0;
   logic [31:0] rs_i = '0;
   logic [31:0] rt_i = '0;
   logic [4:0]  pos_i = '0;
   logic [4:0]  size_m1_i = '0;
   logic [31:0] result_o;
   logic        invalid_o;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk; // 50 MHz

   bitfield_unit dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_i      (op_i),
      .rs_i      (rs_i),
      .rt_i      (rt_i),
      .pos_i     (pos_i),
      .size_m1_i (size_m1_i),
      .result_o  (result_o),
      .invalid_o (invalid_o)
   );

   // Bit-by-bit reference from the requirements
   function automatic logic [31:0] ref_result(input logic op, input logic [31:0] rs,
                                              input logic [31:0] rt, input int pos, input int sm1);
      logic [31:0] r;
      if (!op) begin
         r = '0;
         for (int k = 0; k <= sm1; k++)
            if (pos + k < 32) r[k] = rs[pos + k];
      end else begin
         r = rt;
         for (int k = 0; k <= sm1; k++)
            if (pos + k < 32) r[pos + k] = rs[k];
      end
      return r;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Present a vector at a falling edge, sample one rising edge later
   task automatic apply(input string req, input logic op, input logic [31:0] rs,
                        input logic [31:0] rt, input int pos, input int sm1);
      logic [31:0] exp;
      @(negedge clk);
      op_i = op; rs_i = rs; rt_i = rt; pos_i = 5'(pos); size_m1_i = 5'(sm1);
      @(negedge clk);
      exp = ref_result(op, rs, rt, pos, sm1);
      check(req, result_o, exp);
      check({req, " flag R6"}, {31'd0, invalid_o}, {31'd0, (pos + sm1 + 1) > 32});
   endtask

   task automatic t_reset;
      #1;
      check("R8 reset result", result_o, 32'd0);
      check("R8 reset flag", {31'd0, invalid_o}, 32'd0);
      op_i = 1'b1; rs_i = '1; rt_i = '1; pos_i = 5'd3; size_m1_i = 5'd30;
      repeat (2) @(negedge clk);
      check("R8 reset holds result", result_o, 32'd0);
      check("R8 reset holds flag", {31'd0, invalid_o}, 32'd0);
      rst_n = 1'b1;
   endtask

   task automatic t_extract;
      apply("R1 extract dense", 1'b0, 32'hDEADBEEF, 32'h0, 4, 7);
      apply("R1 extract alt", 1'b0, 32'hAAAA5555, 32'h0, 13, 5);
      apply("R2 extract single bit", 1'b0, 32'h0000_1000, 32'hFFFFFFFF, 12, 0);
      apply("R2 extract zero top", 1'b0, 32'hFFFFFFFF, 32'h0, 0, 9);
      apply("R1 extract top end", 1'b0, 32'h8123_4567, 32'h0, 16, 15);
   endtask

   task automatic t_insert;
      apply("R3 insert ones into zeros", 1'b1, 32'hFFFFFFFF, 32'h0, 8, 3);
      apply("R4 insert zeros into ones", 1'b1, 32'h0, 32'hFFFFFFFF, 5, 10);
      apply("R3 insert pattern", 1'b1, 32'h0000_00A5, 32'h1234_5678, 20, 7);
      apply("R4 insert single bit at 0", 1'b1, 32'hFFFFFFFE, 32'hFFFFFFFF, 0, 0);
   endtask

   task automatic t_full_width;
      apply("R5 full extract", 1'b0, 32'hC0FF_EE11, 32'h0, 0, 31);
      check("R5 full extract is rs", result_o, 32'hC0FF_EE11);
      apply("R5 full insert", 1'b1, 32'h1357_9BDF, 32'hFFFF_0000, 0, 31);
   endtask

   task automatic t_overflow;
      apply("R6 exact fit no flag", 1'b0, 32'hF000_0000, 32'h0, 28, 3);
      apply("R7 extract one past", 1'b0, 32'hF000_0000, 32'h0, 28, 4);
      apply("R7 extract far past", 1'b0, 32'hFFFF_FFFF, 32'h0, 31, 31);
      apply("R7 insert one past", 1'b1, 32'hFFFF_FFFF, 32'h0, 29, 3);
      apply("R7 insert drops high rs", 1'b1, 32'h0000_00F3, 32'h0F0F_0F0F, 30, 7);
   endtask

   task automatic t_rt_ignored;
      logic [31:0] first;
      apply("R9 extract rt zeros", 1'b0, 32'h5A5A_C3C3, 32'h0, 9, 12);
      first = result_o;
      apply("R9 extract rt ones", 1'b0, 32'h5A5A_C3C3, 32'hFFFF_FFFF, 9, 12);
      check("R9 rt has no effect", result_o, first);
   endtask

   task automatic t_latency;
      logic [31:0] exp_a;
      apply("R8 latency first", 1'b0, 32'h0000_FF00, 32'h0, 8, 7);
      exp_a = ref_result(1'b0, 32'h0000_FF00, 32'h0, 8, 7);
      op_i = 1'b1; rs_i = 32'h0; rt_i = 32'hFFFF_FFFF; pos_i = 5'd0; size_m1_i = 5'd15;
      #1;
      check("R8 output held until edge", result_o, exp_a);
      @(negedge clk);
      check("R8 output after edge", result_o, 32'hFFFF_0000);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

   initial begin : main
      t_reset();
      t_extract();
      t_insert();
      t_full_width();
      t_overflow();
      t_rt_ignored();
      t_latency();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end
endmodule